// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind the flag-removal and zero-deletion stage of an HDLC receiver. It watches the first one or two bytes of each incoming frame and decides whether the frame is meant for this station. Frames that are not meant for this station are dropped whole. For accepted frames, the block passes the bytes on to the receive FIFO, one byte per cycle, with an end-of-frame marker.

The block holds two programmable address pairs. Each pair is a 16-bit reference with a 16-bit don't-care mask, and both pairs are compared in parallel. A mask bit of one makes that bit position match any received value, which is how broadcast or group addresses are recognised.

A mode input selects one of three behaviours: no comparison, a single 8-bit address, or a 16-bit address received high byte first. A further option chooses whether the address bytes themselves go into the FIFO ahead of the payload. For each frame that reaches a decision, the block gives one decision pulse carrying the accept flag and the index of the matching pair.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset is released and before any input, the outputs out_valid_o, out_last_o, dec_valid_o, dec_accept_o and dec_idx_o are all zero.
- R2: The mode input is encoded as follows: 2'b00 and 2'b11 mean no comparison, 2'b01 means an 8-bit address, and 2'b10 means a 16-bit address.
- R3: A received address bit matches the reference bit when the two are equal, or when the matching mask bit is 1. With every mask bit of a byte set to 1, any value of that byte matches.
- R4: In 8-bit mode, the first byte of the frame is compared with bits [7:0] of each pair. The decision pulse appears on the cycle after that byte is accepted at the input.
- R5: In 16-bit mode, the first byte is compared with bits [15:8] and the second byte with bits [7:0] of each pair. A pair matches only when both of its bytes match. The decision pulse appears on the cycle after the second byte.
- R6: When no pair matches, the decision pulse carries dec_accept_o=0 and no byte of that frame appears at the output.
- R7: dec_idx_o reports the lowest-numbered matching pair, so pair 0 wins when both pairs match. On a rejected frame, or in no-comparison mode, dec_idx_o is 0.
- R8: With fwd_addr_i=1, an accepted frame's address bytes are output first, in the order they were received, followed by the payload. With fwd_addr_i=0, only the bytes after the address are output.
- R9: A frame that ends before its last address byte arrives (in 16-bit mode, a single-byte frame) produces no decision pulse and no output bytes.
- R10: No byte of a frame appears at the output on a cycle earlier than that frame's decision pulse.
- R11: In no-comparison mode, the decision pulse appears on the cycle after the first byte, with accept=1 and index 0. Every byte of the frame is output.
- R12: out_last_o is 1 on the final byte output for a frame, which is the byte that came in with in_eof_i, and it is 0 on every other output byte.
- R13: Bytes that arrive while no frame is open, that is without in_sof_i and after the previous frame has ended, produce no output and no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Address comparison mode |
| fwd_addr_i | input | 1 | Output the address bytes ahead of the payload |
| pair_addr_i | input | NUM_PAIRS x 16 | Reference address per pair, high byte in [15:8] |
| pair_mask_i | input | NUM_PAIRS x 16 | Don't-care mask per pair, 1 = always match |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | Input byte is the first of a frame |
| in_eof_i | input | 1 | Input byte is the last of a frame |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte to the receive FIFO |
| out_last_o | output | 1 | Output byte ends the frame |
| dec_valid_o | output | 1 | One-cycle decision pulse |
| dec_accept_o | output | 1 | Frame accepted (valid with dec_valid_o) |
| dec_idx_o | output | IDX_W | Index of the matching pair |

## Verification
Some properties are checked by assertions on every cycle:
- a rejected or out-of-range decision never carries a non-zero index;
- an 8-bit frame always gets a decision one cycle after its first byte;
- a one-byte frame in 16-bit mode never produces a decision;
- the output holding stage never has to keep more than one waiting byte.

Other behaviours can only be shown by the bench's scenarios:
- the content of each forwarded byte stream;
- mask-driven broadcast matches;
- the priority between the pairs;
- matches whose high and low bytes fall on different pairs;
- the address-forwarding option;
- the rule that output never starts before the decision.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    AM_NONE  = 2'b00,
    AM_8     = 2'b01,
    AM_16    = 2'b10,
    AM_NONE2 = 2'b11
  } am_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_LO,
    ST_PASS,
    ST_DROP
  } flt_state_e;
endpackage

// File: rtl/haf_byte_cmp.sv
module haf_byte_cmp import hdlc_af_pkg::*; (
  input  logic [BYTE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_hi_o,
  output logic              hit_lo_o
);
  logic [BYTE_W-1:0] diff_hi, diff_lo;

  // a differing bit only counts where the mask does not cover it
  assign diff_hi  = (data_i ^ addr_i[ADDR_W-1:BYTE_W]) & ~mask_i[ADDR_W-1:BYTE_W];
  assign diff_lo  = (data_i ^ addr_i[BYTE_W-1:0])      & ~mask_i[BYTE_W-1:0];
  assign hit_hi_o = (diff_hi == '0);
  assign hit_lo_o = (diff_lo == '0);
endmodule

// File: rtl/haf_prio.sv
module haf_prio #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    // scan downwards so that the lowest set index is the one left in idx_o
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/haf_ctrl.sv
module haf_ctrl import hdlc_af_pkg::*; #(
  parameter int NUM_PAIRS = 2,
  parameter int IDX_W     = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 fwd_addr_i,
  input  logic                 in_valid_i,
  input  logic                 in_sof_i,
  input  logic                 in_eof_i,
  input  logic [BYTE_W-1:0]    in_data_i,
  input  logic [NUM_PAIRS-1:0] hit_hi_i,
  input  logic [NUM_PAIRS-1:0] hit_lo_i,
  output logic                 a_valid_o,
  output logic [BYTE_W-1:0]    a_data_o,
  output logic                 a_last_o,
  output logic                 b_valid_o,
  output logic [BYTE_W-1:0]    b_data_o,
  output logic                 b_last_o,
  output logic                 dec_valid_o,
  output logic                 dec_accept_o,
  output logic [IDX_W-1:0]     dec_idx_o
);
  flt_state_e           st_q, st_d;
  logic [NUM_PAIRS-1:0] hi_q, hi_d;
  logic [BYTE_W-1:0]    held_q, held_d;
  logic [NUM_PAIRS-1:0] dec_vec;
  logic                 dec_go, force_acc, acc;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_any;
  am_mode_e             mode;

  assign mode = am_mode_e'(mode_i);

  haf_prio #(.N(NUM_PAIRS), .IDX_W(IDX_W)) u_prio (
    .vec_i(dec_vec), .idx_o(pick_idx), .any_o(pick_any)
  );

  assign acc = force_acc | pick_any;

  always_comb begin
    st_d      = st_q;
    hi_d      = hi_q;
    held_d    = held_q;
    dec_go    = 1'b0;
    dec_vec   = '0;
    force_acc = 1'b0;
    a_valid_o = 1'b0;
    a_data_o  = in_data_i;
    a_last_o  = in_eof_i;
    b_valid_o = 1'b0;
    b_data_o  = in_data_i;
    b_last_o  = in_eof_i;
    if (in_valid_i) begin
      if (in_sof_i) begin
        unique case (mode)
          AM_8: begin
            dec_go    = 1'b1;
            dec_vec   = hit_lo_i;
            a_valid_o = pick_any & fwd_addr_i;
            st_d      = in_eof_i ? ST_IDLE : (pick_any ? ST_PASS : ST_DROP);
          end
          AM_16: begin
            if (in_eof_i) st_d = ST_IDLE;     // address never completes
            else begin
              hi_d   = hit_hi_i;
              held_d = in_data_i;
              st_d   = ST_WAIT_LO;
            end
          end
          default: begin
            dec_go    = 1'b1;
            force_acc = 1'b1;
            a_valid_o = 1'b1;
            st_d      = in_eof_i ? ST_IDLE : ST_PASS;
          end
        endcase
      end else begin
        unique case (st_q)
          ST_WAIT_LO: begin
            dec_go  = 1'b1;
            dec_vec = hi_q & hit_lo_i;
            if (pick_any && fwd_addr_i) begin
              a_valid_o = 1'b1;
              a_data_o  = held_q;
              a_last_o  = 1'b0;
              b_valid_o = 1'b1;
            end
            st_d = in_eof_i ? ST_IDLE : (pick_any ? ST_PASS : ST_DROP);
          end
          ST_PASS: begin
            a_valid_o = 1'b1;
            if (in_eof_i) st_d = ST_IDLE;
          end
          ST_DROP: if (in_eof_i) st_d = ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      hi_q         <= '0;
      held_q       <= '0;
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_idx_o    <= '0;
    end else begin
      st_q         <= st_d;
      hi_q         <= hi_d;
      held_q       <= held_d;
      dec_valid_o  <= dec_go;
      dec_accept_o <= dec_go & acc;
      dec_idx_o    <= (dec_go && !force_acc) ? pick_idx : '0;
    end
  end

  assert_idx_zero_on_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !dec_accept_o) |-> (dec_idx_o == '0));

  assert_idx_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (int'(dec_idx_o) < NUM_PAIRS));

  assert_short_no_decision_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && in_eof_i && mode_i == 2'b10) |=> !dec_valid_o);

  assert_decide_first_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && mode_i == 2'b01) |=> dec_valid_o);
endmodule

// File: rtl/haf_out.sv
module haf_out import hdlc_af_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_valid_i,
  input  logic [BYTE_W-1:0] a_data_i,
  input  logic              a_last_i,
  input  logic              b_valid_i,
  input  logic [BYTE_W-1:0] b_data_i,
  input  logic              b_last_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_last_o
);
  logic              pend_v;
  logic [BYTE_W-1:0] pend_d;
  logic              pend_l;

  // one waiting slot absorbs the two-byte burst at a 16-bit accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
      pend_v      <= 1'b0;
      pend_d      <= '0;
      pend_l      <= 1'b0;
    end else if (pend_v) begin
      out_valid_o <= 1'b1;
      out_data_o  <= pend_d;
      out_last_o  <= pend_l;
      pend_v      <= a_valid_i;
      pend_d      <= a_data_i;
      pend_l      <= a_last_i;
    end else if (a_valid_i) begin
      out_valid_o <= 1'b1;
      out_data_o  <= a_data_i;
      out_last_o  <= a_last_i;
      pend_v      <= b_valid_i;
      pend_d      <= b_data_i;
      pend_l      <= b_last_i;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_v && b_valid_i));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter import hdlc_af_pkg::*; #(
  parameter  int NUM_PAIRS = 2,
  localparam int IDX_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [1:0]                        mode_i,
  input  logic                              fwd_addr_i,
  input  logic [NUM_PAIRS-1:0][ADDR_W-1:0]  pair_addr_i,
  input  logic [NUM_PAIRS-1:0][ADDR_W-1:0]  pair_mask_i,
  input  logic                              in_valid_i,
  input  logic                              in_sof_i,
  input  logic                              in_eof_i,
  input  logic [BYTE_W-1:0]                 in_data_i,
  output logic                              out_valid_o,
  output logic [BYTE_W-1:0]                 out_data_o,
  output logic                              out_last_o,
  output logic                              dec_valid_o,
  output logic                              dec_accept_o,
  output logic [IDX_W-1:0]                  dec_idx_o
);
  logic [NUM_PAIRS-1:0] hit_hi, hit_lo;
  logic                 a_v, a_l, b_v, b_l;
  logic [BYTE_W-1:0]    a_d, b_d;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    haf_byte_cmp u_cmp (
      .data_i  (in_data_i),
      .addr_i  (pair_addr_i[g]),
      .mask_i  (pair_mask_i[g]),
      .hit_hi_o(hit_hi[g]),
      .hit_lo_o(hit_lo[g])
    );
  end

  haf_ctrl #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .fwd_addr_i,
    .in_valid_i, .in_sof_i, .in_eof_i, .in_data_i,
    .hit_hi_i    (hit_hi),
    .hit_lo_i    (hit_lo),
    .a_valid_o   (a_v), .a_data_o(a_d), .a_last_o(a_l),
    .b_valid_o   (b_v), .b_data_o(b_d), .b_last_o(b_l),
    .dec_valid_o, .dec_accept_o, .dec_idx_o
  );

  haf_out u_out (
    .clk_i, .rst_ni,
    .a_valid_i(a_v), .a_data_i(a_d), .a_last_i(a_l),
    .b_valid_i(b_v), .b_data_i(b_d), .b_last_i(b_l),
    .out_valid_o, .out_data_o, .out_last_o
  );
endmodule

// File: tb/sim_hdlc_addr_filter.sv
`timescale 1ns/1ps
module sim_hdlc_addr_filter;
  localparam int NP = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             fwd = 1'b0;
  logic [NP-1:0][15:0] pa = '0;
  logic [NP-1:0][15:0] pm = '0;
  logic             iv = 1'b0, isof = 1'b0, ieof = 1'b0;
  logic [7:0]       idat = '0;
  logic             ov, ol, dv, da;
  logic [7:0]       od;
  logic [0:0]       di;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef logic [7:0] bq_t [$];
  bq_t fq;
  logic [7:0] mo_d [$];
  bit         mo_l [$];
  int         mo_c [$];
  bit         md_a [$];
  int         md_i [$];
  int         md_c [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdlc_addr_filter #(.NUM_PAIRS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fwd_addr_i(fwd),
    .pair_addr_i(pa), .pair_mask_i(pm),
    .in_valid_i(iv), .in_sof_i(isof), .in_eof_i(ieof), .in_data_i(idat),
    .out_valid_o(ov), .out_data_o(od), .out_last_o(ol),
    .dec_valid_o(dv), .dec_accept_o(da), .dec_idx_o(di)
  );

  always @(negedge clk) begin
    if (rst_n && ov) begin mo_d.push_back(od); mo_l.push_back(ol); mo_c.push_back(cyc); end
    if (rst_n && dv) begin md_a.push_back(da); md_i.push_back(int'(di)); md_c.push_back(cyc); end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit bmatch(input logic [7:0] b, input logic [7:0] r, input logic [7:0] m);
    for (int k = 0; k < 8; k++) if (!m[k] && (b[k] !== r[k])) return 1'b0;
    return 1'b1;
  endfunction

  // drive fq as one frame, then compare against a model of the requirements
  task automatic run_frame(input int gap, input bit no_sof, input string tag);
    int sc [$];
    int naddr, dpos, ei, first;
    bit exp_dec, exp_acc;
    int exp_idx;
    mo_d.delete(); mo_l.delete(); mo_c.delete();
    md_a.delete(); md_i.delete(); md_c.delete();
    foreach (fq[i]) begin
      @(posedge clk); #1;
      iv = 1'b1; isof = (i == 0) && !no_sof; ieof = (i == fq.size() - 1); idat = fq[i];
      sc.push_back(cyc);
      if (gap != 0) begin @(posedge clk); #1; iv = 1'b0; isof = 1'b0; ieof = 1'b0; end
    end
    @(posedge clk); #1; iv = 1'b0; isof = 1'b0; ieof = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    naddr = (mode == 2'b01) ? 1 : (mode == 2'b10) ? 2 : 0;
    dpos = (naddr == 0) ? 0 : naddr - 1;
    exp_dec = !no_sof && (fq.size() > dpos);
    exp_acc = 1'b0; exp_idx = 0;
    if (exp_dec) begin
      if (naddr == 0) exp_acc = 1'b1;
      else for (int p = NP - 1; p >= 0; p--) begin
        bit h;
        if (naddr == 1) h = bmatch(fq[0], pa[p][7:0], pm[p][7:0]);
        else h = bmatch(fq[0], pa[p][15:8], pm[p][15:8]) && bmatch(fq[1], pa[p][7:0], pm[p][7:0]);
        if (h) begin exp_acc = 1'b1; exp_idx = p; end
      end
    end
    chk(md_c.size() == int'(exp_dec), tag, "decision count", md_c.size(), int'(exp_dec));
    if (exp_dec && md_c.size() == 1) begin
      chk(md_c[0] == sc[dpos] + 1, tag, "decision cycle", md_c[0], sc[dpos] + 1);
      chk(md_a[0] == exp_acc, tag, "accept", int'(md_a[0]), int'(exp_acc));
      chk(md_i[0] == exp_idx, tag, "index", md_i[0], exp_idx);
    end
    first = fwd ? 0 : naddr;
    ei = (exp_dec && exp_acc) ? fq.size() - first : 0;
    chk(mo_d.size() == ei, tag, "output byte count", mo_d.size(), ei);
    if (mo_d.size() == ei) begin
      for (int j = 0; j < ei; j++) begin
        chk(mo_d[j] == fq[first + j], tag, "output byte", int'(mo_d[j]), int'(fq[first + j]));
        chk(mo_l[j] == (j == ei - 1), "R12", "last marker", int'(mo_l[j]), int'(j == ei - 1));
      end
      if (ei > 0 && md_c.size() == 1)
        chk(mo_c[0] >= md_c[0], "R10", "first output before decision", mo_c[0], md_c[0]);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!ov && !ol && !dv && !da && di == 0, "R1", "outputs in reset", int'({ov, ol, dv, da}), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ov && !ol && !dv && !da && di == 0, "R1", "outputs after reset", int'({ov, ol, dv, da}), 0);
  endtask

  task automatic t_transparent;
    mode = 2'b00; fwd = 1'b0;
    fq.delete(); fq.push_back(8'h12); fq.push_back(8'h34); fq.push_back(8'h56);
    run_frame(0, 0, "R11");
    mode = 2'b11;
    run_frame(1, 0, "R2");
  endtask

  task automatic t_8bit;
    mode = 2'b01;
    pa[0] = 16'h00A1; pm[0] = 16'h0000;
    pa[1] = 16'h00B2; pm[1] = 16'h0000;
    fwd = 1'b0;
    fq.delete(); fq.push_back(8'hA1); fq.push_back(8'h01); fq.push_back(8'h02);
    run_frame(0, 0, "R4");
    fwd = 1'b1;
    fq[0] = 8'hB2;
    run_frame(0, 0, "R8");
    fq[0] = 8'hC3;
    run_frame(0, 0, "R6");
  endtask

  task automatic t_priority_mask;
    mode = 2'b01; fwd = 1'b0;
    pa[0] = 16'h0055; pm[0] = 16'h0000;
    pa[1] = 16'h0050; pm[1] = 16'h000F;
    fq.delete(); fq.push_back(8'h55); fq.push_back(8'h99);
    run_frame(0, 0, "R7");
    fq[0] = 8'h5E;
    run_frame(0, 0, "R3");
    pm[1] = 16'h00FF;
    fq[0] = 8'h01;
    run_frame(1, 0, "R3");
  endtask

  task automatic t_16bit;
    mode = 2'b10; fwd = 1'b1;
    pa[0] = 16'h1234; pm[0] = 16'h0000;
    pa[1] = 16'hABCD; pm[1] = 16'h0000;
    fq.delete(); fq.push_back(8'hAB); fq.push_back(8'hCD); fq.push_back(8'h77); fq.push_back(8'h88);
    run_frame(0, 0, "R5");
    run_frame(1, 0, "R8");
    fwd = 1'b0;
    run_frame(0, 0, "R5");
    fq[0] = 8'h12; fq[1] = 8'hCD;     // high of pair 0, low of pair 1
    run_frame(0, 0, "R5");
    fq.delete(); fq.push_back(8'h12); fq.push_back(8'h34);
    run_frame(0, 0, "R8");
  endtask

  task automatic t_short;
    mode = 2'b10; fwd = 1'b1;
    fq.delete(); fq.push_back(8'h12);
    run_frame(0, 0, "R9");
  endtask

  task automatic t_outside;
    mode = 2'b00; fwd = 1'b1;
    fq.delete(); fq.push_back(8'h21); fq.push_back(8'h22); fq.push_back(8'h23);
    run_frame(0, 1, "R13");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_transparent();
    t_8bit();
    t_priority_mask();
    t_16bit();
    t_short();
    t_outside();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule